// File: doc/BRIEF.md
# Controller Capture Unit

This block takes a snapshot of a 16-bit live button-state word and holds it in two byte-wide data registers that a processor reads over a memory-mapped bus. One byte-wide control register steers the block. Every write to that register also serves as a command. The processor reads the control register back through a dedicated read port. In that readback, bit 1 shows whether a timed capture is still in flight.

A capture comes about in one of two ways. The first is a timed capture. Any control write with the cancel bit clear starts a countdown of a fixed number of cycles, and when the countdown ends the input word is latched. A write with the cancel bit set kills the countdown before it can latch anything. The second is a software-paced capture. Writing the arm bit loads a 32-step down-counter, and the processor then toggles a clock bit, one register write per step. Each write whose clock bit has the value the counter expects moves the counter down by one. A write with the wrong value is ignored. The step taken from zero latches the word and ends the sequence.

Top module: `padcap_unit`

## Requirements
- R1: After reset, the control readback is 0x00, both data outputs are 0x00, no timed capture is pending and no software sequence is active.
- R2: Every control write stores the written byte with bit 2 forced to 1. The readback then returns bits 7..2 and bit 0 of that stored value, and bit 1 of the readback is the busy flag of the timed capture.
- R3: A write with bit 0 (cancel) set clears a pending timed capture. The busy flag reads 0 after that edge, and the cancelled capture never latches the input word.
- R4: A write with bit 0 clear while no timed capture is pending starts one. The busy flag reads 1 for exactly DUR_CYCLES cycles, starting the cycle after the write. At the edge where it drops, the input word present at that edge is latched.
- R5: A write with bit 0 clear while a timed capture is pending does not restart or extend it. The total busy time stays DUR_CYCLES.
- R6: A write with bit 5 set loads the software step counter with 31, from any state. This includes restarting a sequence already in progress. The data outputs do not change at that write.
- R7: During a software sequence, the expected clock bit is bit 4 = 1 when the counter is odd and bit 4 = 0 when it is even. Only a write with bit 5 clear and the expected bit 4 moves the counter down by one. A write with the wrong bit 4 leaves the counter unchanged.
- R8: A matching write with the counter at 0 latches the input word and ends the sequence, so 16 set/clear pairs after arming complete one capture. Until then the data outputs are unchanged, and once the sequence has ended, further clock-bit writes latch nothing.
- R9: A capture puts input bits 7:0 on the low data output and input bits 15:8 on the high data output.
- R10: The data outputs change only on the edge of a timed completion or of a final software step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | One-cycle write strobe for the control register |
| ctlWrData | input | 8 | Byte written to the control register |
| ctlRdData | output | 8 | Control register readback, with bit 1 showing the live busy flag |
| padWord | input | 16 | Live button-state word |
| dataLo | output | 8 | Captured bits 7:0 |
| dataHi | output | 8 | Captured bits 15:8 |

## Verification
The bench measures the busy window cycle by cycle. It re-issues a start in the middle of a pending capture, so a design that reloads its countdown would show a busy time longer than DUR_CYCLES. It cancels a capture partway through and watches the data outputs for longer than the full window, which catches a design that still latches after a cancel. The software sequence includes wrong-parity writes, a re-arm in the middle of a sequence, and writes after the sequence has ended. A design that counts every write, that forgets to reload on re-arm, or that captures off by one step would therefore change the data outputs at the wrong write, and the scoreboard reports that as an unexpected or mismatched capture.

// File: rtl/padcap_pkg.sv
package padcap_pkg;

  localparam int CTL_W     = 8;
  localparam int ARM_BIT   = 5;  // arm a software-paced sequence
  localparam int CLK_BIT   = 4;  // software step clock
  localparam int RDEN_BIT  = 2;  // forced to one on every write
  localparam int BUSY_BIT  = 1;  // timed capture pending (readback only)
  localparam int ABORT_BIT = 0;  // cancel a timed capture

  typedef struct packed {
    logic ctlLoad;   // store the written byte
    logic capture;   // latch the input word
  } padcap_strobe_t;

endpackage

// File: rtl/padcap_ctrl.sv
module padcap_ctrl
  import padcap_pkg::*;
#(
  parameter int DUR_CYCLES = 32,
  parameter int SW_STEPS   = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wrEn,
  input  logic           wrArm,
  input  logic           wrClk,
  input  logic           wrAbort,
  output padcap_strobe_t strb,
  output logic           busy
);

  localparam int TMR_W = $clog2(DUR_CYCLES + 1);
  localparam int CNT_W = $clog2(SW_STEPS);

  logic             pending;
  logic [TMR_W-1:0] remain;
  logic             swActive;
  logic [CNT_W-1:0] swCount;

  logic cancelReq, startReq, autoDone, swMatch, swDone;

  always_comb begin
    cancelReq = wrEn && wrAbort;
    startReq  = wrEn && !wrAbort && !pending;
    autoDone  = pending && (remain == TMR_W'(1)) && !cancelReq;
    swMatch   = wrEn && !wrArm && swActive && (wrClk == swCount[0]);
    swDone    = swMatch && (swCount == '0);
  end

  // timed capture countdown
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      remain  <= '0;
    end else if (cancelReq || autoDone) begin
      pending <= 1'b0;
      remain  <= '0;
    end else if (startReq) begin
      pending <= 1'b1;
      remain  <= TMR_W'(DUR_CYCLES);
    end else if (pending) begin
      remain  <= remain - 1'b1;
    end
  end

  // software-paced step counter
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      swActive <= 1'b0;
      swCount  <= '0;
    end else if (wrEn && wrArm) begin
      swActive <= 1'b1;
      swCount  <= CNT_W'(SW_STEPS - 1);
    end else if (swDone) begin
      swActive <= 1'b0;
    end else if (swMatch) begin
      swCount  <= swCount - 1'b1;
    end
  end

  always_comb begin
    strb.ctlLoad = wrEn;
    strb.capture = autoDone || swDone;
    busy         = pending;
  end

endmodule

// File: rtl/padcap_dpath.sv
module padcap_dpath
  import padcap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  padcap_strobe_t             strb,
  input  logic [CTL_W-1:0]           wrData,
  input  logic                       busy,
  input  logic [2*DATA_W-1:0]        padWord,
  output logic [CTL_W-1:0]           ctlRd,
  output logic [1:0][DATA_W-1:0]     dataLanes
);

  localparam logic [CTL_W-1:0] RDEN_MASK = CTL_W'(1) << RDEN_BIT;
  localparam logic [CTL_W-1:0] BUSY_MASK = CTL_W'(1) << BUSY_BIT;

  logic [CTL_W-1:0] ctlReg;

  always_ff @(posedge clk) begin
    if (!rst_n)            ctlReg <= '0;
    else if (strb.ctlLoad) ctlReg <= wrData | RDEN_MASK;
  end

  always_comb ctlRd = (ctlReg & ~BUSY_MASK) | (busy ? BUSY_MASK : '0);

  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)            dataLanes[g] <= '0;
      else if (strb.capture) dataLanes[g] <= padWord[g*DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/padcap_unit.sv
module padcap_unit
  import padcap_pkg::*;
#(
  parameter int DUR_CYCLES = 32,
  parameter int SW_STEPS   = 32,
  parameter int DATA_W     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctlWrEn,
  input  logic [CTL_W-1:0]    ctlWrData,
  output logic [CTL_W-1:0]    ctlRdData,
  input  logic [2*DATA_W-1:0] padWord,
  output logic [DATA_W-1:0]   dataLo,
  output logic [DATA_W-1:0]   dataHi
);

  padcap_strobe_t           strb;
  logic                     busy;
  logic [1:0][DATA_W-1:0]   dataLanes;

  padcap_ctrl #(.DUR_CYCLES(DUR_CYCLES), .SW_STEPS(SW_STEPS)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrEn    (ctlWrEn),
    .wrArm   (ctlWrData[ARM_BIT]),
    .wrClk   (ctlWrData[CLK_BIT]),
    .wrAbort (ctlWrData[ABORT_BIT]),
    .strb    (strb),
    .busy    (busy)
  );

  padcap_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .wrData    (ctlWrData),
    .busy      (busy),
    .padWord   (padWord),
    .ctlRd     (ctlRdData),
    .dataLanes (dataLanes)
  );

  assign dataLo = dataLanes[0];
  assign dataHi = dataLanes[1];

endmodule

// File: rtl/padcap_checker.sv
module padcap_checker #(
  parameter int DUR_CYCLES = 32,
  parameter int DATA_W     = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ctlWrEn,
  input logic [7:0]          ctlWrData,
  input logic [7:0]          ctlRdData,
  input logic [2*DATA_W-1:0] padWord,
  input logic [DATA_W-1:0]   dataLo,
  input logic [DATA_W-1:0]   dataHi
);

  localparam int RUN_W = $clog2(DUR_CYCLES + 2);

  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rst_n)                             busyRun <= '0;
    else if (!ctlRdData[1])                 busyRun <= '0;
    else if (busyRun != {RUN_W{1'b1}})      busyRun <= busyRun + 1'b1;
  end

  assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctlWrEn |=> ((ctlRdData & 8'hFD) == (($past(ctlWrData) | 8'h04) & 8'hFD)));

  assert_cancel_idles_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlWrEn && ctlWrData[0]) |=> !ctlRdData[1]);

  assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlWrEn && !ctlWrData[0] && !ctlRdData[1]) |=> ctlRdData[1]);

  assert_busy_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busyRun <= RUN_W'(DUR_CYCLES));

  assert_lane_map_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctlRdData[1]) && !$past(ctlWrEn)) |->
      (dataLo == $past(padWord[DATA_W-1:0]) && dataHi == $past(padWord[2*DATA_W-1:DATA_W])));

  assert_data_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctlWrEn && !ctlRdData[1]) |=> ($stable(dataLo) && $stable(dataHi)));

endmodule

bind padcap_unit padcap_checker #(.DUR_CYCLES(DUR_CYCLES), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctlWrEn   (ctlWrEn),
  .ctlWrData (ctlWrData),
  .ctlRdData (ctlRdData),
  .padWord   (padWord),
  .dataLo    (dataLo),
  .dataHi    (dataHi)
);

// File: tb/padcap_unit_tb.sv
module padcap_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DUR        = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctlWrEn = 1'b0;
  logic [7:0]  ctlWrData = '0;
  logic [7:0]  ctlRdData;
  logic [15:0] padWord = '0;
  logic [7:0]  dataLo, dataHi;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  padcap_unit #(.DUR_CYCLES(DUR)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .ctlRdData(ctlRdData), .padWord(padWord), .dataLo(dataLo), .dataHi(dataHi)
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic ctlWrite(input logic [7:0] v);
    @(negedge clk);
    ctlWrEn = 1'b1; ctlWrData = v;
    @(negedge clk);
    ctlWrEn = 1'b0; ctlWrData = '0;
  endtask

  // driver side of the scoreboard
  task automatic expectCapture(input logic [15:0] w);
    expQ.push_back(w);
  endtask

  task automatic finishRun();
    if (expQ.size() != 0) checkEq("R4/R8 captures left unseen", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // monitor: every change of the data outputs must match the next expected capture
  initial begin : monitor
    logic [15:0] prev, cur;
    wait (rst_n === 1'b1);
    @(negedge clk);
    prev = {dataHi, dataLo};
    forever begin
      @(negedge clk);
      cur = {dataHi, dataLo};
      if (cur !== prev) begin
        if (expQ.size() == 0) checkEq("R10 unexpected capture", cur, prev);
        else checkEq("R9 captured word", cur, expQ.pop_front());
      end
      prev = cur;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finishRun();
    end
  end

  initial begin : stimulus
    int cnt;
    repeat (3) @(negedge clk);
    checkEq("R1 readback in reset", ctlRdData, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    checkEq("R1 readback", ctlRdData, 8'h00);
    checkEq("R1 data", {dataHi, dataLo}, 16'h0000);

    // R2: readback with bit 2 forced, cancel bit set so nothing starts
    ctlWrite(8'hC9);
    checkEq("R2 readback", ctlRdData, 8'hCD);
    checkEq("R10 data after plain write", {dataHi, dataLo}, 16'h0000);

    // R4: timed capture, busy exactly DUR cycles
    padWord = 16'hA55A;
    expectCapture(16'hA55A);
    ctlWrite(8'h00);
    checkEq("R2/R4 readback while busy", ctlRdData, 8'h06);
    cnt = 0;
    while (ctlRdData[1] && cnt < 4*DUR) begin cnt++; @(negedge clk); end
    checkEq("R4 busy length", cnt, DUR);
    checkEq("R9 low/high lanes after timed capture", {dataHi, dataLo}, 16'hA55A);
    checkEq("R4 readback after completion", ctlRdData, 8'h04);

    // R5: restart during pending does not extend
    padWord = 16'h3C96;
    expectCapture(16'h3C96);
    ctlWrite(8'h00);
    cnt = 0;
    for (int i = 0; i < DUR + 10; i++) begin
      if (ctlRdData[1]) cnt++;
      ctlWrEn = (i == 10); ctlWrData = '0;
      @(negedge clk);
    end
    checkEq("R5 busy length with restart", cnt, DUR);
    checkEq("R5 captured word", {dataHi, dataLo}, 16'h3C96);

    // R3: cancel a pending capture
    padWord = 16'h7E81;
    ctlWrite(8'h00);
    repeat (5) @(negedge clk);
    ctlWrite(8'h01);
    checkEq("R3 busy cleared", ctlRdData, 8'h05);
    cnt = 0;
    for (int i = 0; i < DUR + 5; i++) begin
      if (ctlRdData[1]) cnt++;
      @(negedge clk);
    end
    checkEq("R3 no busy after cancel", cnt, 0);
    checkEq("R3 data kept", {dataHi, dataLo}, 16'h3C96);

    // R6..R8: software-paced capture, cancel bit set on every write
    padWord = 16'hB74E;
    ctlWrite(8'h21);
    checkEq("R6 data unchanged at arm", {dataHi, dataLo}, 16'h3C96);
    ctlWrite(8'h01);                       // wrong parity, ignored (R7)
    ctlWrite(8'h11);                       // 31 -> 30
    checkEq("R2 readback sw write", ctlRdData, 8'h15);
    ctlWrite(8'h11);                       // wrong parity, ignored (R7)
    ctlWrite(8'h01);                       // 30 -> 29
    for (int i = 0; i < 14; i++) begin ctlWrite(8'h11); ctlWrite(8'h01); end  // 29 -> 1
    ctlWrite(8'h11);                       // 1 -> 0
    checkEq("R7/R8 no capture before last step", {dataHi, dataLo}, 16'h3C96);
    expectCapture(16'hB74E);
    ctlWrite(8'h01);                       // final step
    checkEq("R8/R9 software capture", {dataHi, dataLo}, 16'hB74E);
    checkEq("R9 low lane", dataLo, 8'h4E);

    // R8: after the end, clock writes latch nothing
    padWord = 16'h6D29;
    for (int i = 0; i < 20; i++) begin ctlWrite(8'h11); ctlWrite(8'h01); end
    checkEq("R8 idle after end", {dataHi, dataLo}, 16'hB74E);

    // R6: re-arm in the middle restarts the full count
    ctlWrite(8'h21);
    for (int i = 0; i < 10; i++) ctlWrite((i % 2 == 0) ? 8'h11 : 8'h01);
    ctlWrite(8'h21);
    for (int i = 0; i < 31; i++) ctlWrite((i % 2 == 0) ? 8'h11 : 8'h01);
    checkEq("R6 re-arm restarts count", {dataHi, dataLo}, 16'hB74E);
    expectCapture(16'h6D29);
    ctlWrite(8'h01);
    checkEq("R6/R8 capture after re-arm", {dataHi, dataLo}, 16'h6D29);

    repeat (3) @(negedge clk);
    done = 1'b1;
    finishRun();
  end

endmodule